// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Responder

This block is the memory side of a serial-flash read that returns data on two lines at once. A host selects it with an active-low select and supplies a serial clock, idle low. The host shifts in a one-byte command and then a three- or four-byte start address on the single input line. After zero or eight idle clocks the block returns bytes from a small internal read-only array. It sends two bits per serial clock and moves to the next address after each byte, wrapping at the end of the array. The data pins are modelled as separate input, output and enable signals so that the pad tristate can sit outside the block.

The serial pins are sampled by the block's own system clock through synchronisers, so every serial edge is seen as a one-cycle pulse. The transfer has no back-pressure: the host's serial clock alone paces it, and the block must have each bit pair ready before the host's next rising edge. The host must keep each serial clock half-period at least 4 system clocks long and must hold select high for at least 4 system clocks between transfers. The extended-addressing and latency inputs must be stable while select is low.

Top module: `dual_read_responder`

## Requirements
- R1: Command byte 3Bh with `ext_addr` low is followed by exactly 24 address bits before the latency phase.
- R2: Command byte 3Bh with `ext_addr` high is followed by exactly 32 address bits.
- R3: Command byte 3Ch is followed by exactly 32 address bits whatever the level of `ext_addr`.
- R4: Command and address bits are taken from `io0_in` on rising `sck` edges, most significant bit first.
- R5: With `lat_sel` low there are no dummy clocks. With `lat_sel` high the 8 clocks after the last address bit are dummy clocks, and `io0_in` has no effect on the data during them.
- R6: Data changes only after falling `sck` edges, one bit pair per edge. `dq_out[1]` carries bits 7, 5, 3 and 1 of each byte in turn, and `dq_out[0]` carries bits 6, 4, 2 and 0. The first pair is driven on the first falling edge after the latency phase.
- R7: The read address rises by one after the fourth bit pair of each byte.
- R8: Only the low ADDR_BITS address bits select a byte (default 10, 1024 bytes). Reading past the last byte continues from byte 0 for as long as select stays low.
- R9: A high `cs_n` turns `dq_oe` off at once at any point of a transfer. The next transfer starts again with a command byte.
- R10: Any command byte other than 3Bh or 3Ch leaves `dq_oe` off for the rest of that transfer.
- R11: `dq_oe` is 00 during the command, address and dummy phases, and it is 11 from the first data pair until select rises.
- R12: The array byte at masked address a is ((a[7:0] XOR A5h) + a[9:8]) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_addr | input | 1 | High selects 32 address bits for command 3Bh |
| lat_sel | input | 1 | Latency choice: 0 gives no dummy clocks, 1 gives 8 |
| cs_n | input | 1 | Active-low select from the host |
| sck | input | 1 | Serial clock from the host, idle low |
| io0_in | input | 1 | Input half of data line 0 (command and address) |
| dq_out | output | 2 | Read data bit pair; bit 1 drives line 1, bit 0 drives line 0 |
| dq_oe | output | 2 | Output enable for each data line |

## Verification
A table of reads runs both commands under both addressing settings and both latency choices. Each mode shifts a different number of bits before data starts, so a wrong address length or dummy count shows up as a wrong byte value. The start addresses are chosen to have asymmetric bit patterns, which exposes bit-order and pair-order errors. Some also set address bits above the array size, and some start just below the top of the array so that the read crosses the wrap. Directed runs then abort a read in the middle of a byte and send unrecognised commands, and a read follows each one to show that the block starts again cleanly.

// File: rtl/dor_pkg.sv
package dor_pkg;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } rd_state_t;

  localparam logic [7:0] CMD_DUAL_RD   = 8'h3B;
  localparam logic [7:0] CMD_DUAL_RD_W = 8'h3C;

  // Fixed array content: low byte XOR A5h, plus the sum of the higher bytes.
  function automatic logic [7:0] fill_byte(input logic [31:0] a);
    return (a[7:0] ^ 8'hA5) + a[15:8] + a[23:16] + a[31:24];
  endfunction

endpackage

// File: rtl/dor_pin_sync.sv
module dor_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic io0,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_idle,
  output logic io0_s
);
  // each stage holds {sck, cs_n, io0}
  logic [2:0] stg [STAGES];
  logic       sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= 3'b010;
      sck_prev <= 1'b0;
    end else begin
      stg[0] <= {sck, cs_n, io0};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sck_prev <= stg[STAGES-1][2];
    end
  end

  assign sck_rise = stg[STAGES-1][2] & ~sck_prev;
  assign sck_fall = ~stg[STAGES-1][2] & sck_prev;
  assign cs_idle  = stg[STAGES-1][1];
  assign io0_s    = stg[STAGES-1][0];
endmodule

// File: rtl/dor_cmd_fsm.sv
module dor_cmd_fsm
  import dor_pkg::*;
#(
  parameter int ADDR_BITS  = 10,
  parameter int DUMMY_LONG = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_idle,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 din,
  input  logic                 ext_addr,
  input  logic                 lat_sel,
  output rd_state_t            state,
  output logic                 load,
  output logic [ADDR_BITS-1:0] load_addr,
  output logic                 drive
);
  localparam int SW = (ADDR_BITS - 1 > 7) ? ADDR_BITS - 1 : 7;
  localparam int DW = $clog2(DUMMY_LONG + 1);
  localparam logic [DW-1:0] DLAST = DW'(DUMMY_LONG - 1);

  logic [SW-1:0] shreg;
  logic [SW:0]   sh_next;
  logic [4:0]    bcnt;
  logic [DW-1:0] dcnt;
  logic          wide;
  logic [7:0]    opc_now;
  logic          addr_done;

  assign sh_next   = {shreg, din};
  assign opc_now   = {shreg[6:0], din};
  assign addr_done = rise && (bcnt == (wide ? 5'd31 : 5'd23));
  assign load      = (state == ST_ADDR) && addr_done && !cs_idle;
  assign load_addr = sh_next[ADDR_BITS-1:0];
  assign drive     = (state == ST_DATA) && fall && !cs_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OPC;
      shreg <= '0;
      bcnt  <= '0;
      dcnt  <= '0;
      wide  <= 1'b0;
    end else if (cs_idle) begin
      state <= ST_OPC;
      bcnt  <= '0;
      dcnt  <= '0;
    end else begin
      if (rise) shreg <= sh_next[SW-1:0];
      case (state)
        ST_OPC: if (rise) begin
          if (bcnt == 5'd7) begin
            bcnt <= '0;
            if (opc_now == CMD_DUAL_RD) begin
              wide  <= ext_addr;
              state <= ST_ADDR;
            end else if (opc_now == CMD_DUAL_RD_W) begin
              wide  <= 1'b1;
              state <= ST_ADDR;
            end else begin
              state <= ST_SKIP;
            end
          end else begin
            bcnt <= bcnt + 5'd1;
          end
        end
        ST_ADDR: if (rise) begin
          if (addr_done) begin
            bcnt  <= '0;
            dcnt  <= '0;
            state <= lat_sel ? ST_DUMMY : ST_DATA;
          end else begin
            bcnt <= bcnt + 5'd1;
          end
        end
        ST_DUMMY: if (fall) begin
          if (dcnt == DLAST) state <= ST_DATA;
          else dcnt <= dcnt + DW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dor_serializer.sv
module dor_serializer #(
  parameter int ADDR_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_idle,
  input  logic                 load,
  input  logic [ADDR_BITS-1:0] load_addr,
  input  logic                 drive,
  input  logic [7:0]           rd_data,
  output logic [ADDR_BITS-1:0] rd_addr,
  output logic [1:0]           dq,
  output logic                 oe,
  output logic [1:0]           pair
);
  logic [5:0] rest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
      rest    <= '0;
      dq      <= '0;
      oe      <= 1'b0;
      pair    <= '0;
    end else if (cs_idle) begin
      oe   <= 1'b0;
      pair <= '0;
    end else if (load) begin
      rd_addr <= load_addr;
      pair    <= '0;
    end else if (drive) begin
      oe   <= 1'b1;
      pair <= pair + 2'd1;
      if (pair == 2'd0) begin
        dq      <= rd_data[7:6];
        rest    <= rd_data[5:0];
        rd_addr <= rd_addr + ADDR_BITS'(1);
      end else begin
        dq   <= rest[5:4];
        rest <= {rest[3:0], 2'b00};
      end
    end
  end
endmodule

// File: rtl/dor_array.sv
module dor_array
  import dor_pkg::*;
#(
  parameter int ADDR_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_BITS-1:0] addr,
  output logic [7:0]           q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= fill_byte(32'(addr));
  end
endmodule

// File: rtl/dual_read_responder.sv
module dual_read_responder
  import dor_pkg::*;
#(
  parameter int ADDR_BITS   = 10,
  parameter int SYNC_STAGES = 2,
  parameter int DUMMY_LONG  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_addr,
  input  logic       lat_sel,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       io0_in,
  output logic [1:0] dq_out,
  output logic [1:0] dq_oe
);
  logic                 sck_rise, sck_fall, cs_idle, io0_s;
  rd_state_t            st;
  logic                 load, drive;
  logic [ADDR_BITS-1:0] load_addr, cur_addr;
  logic [7:0]           rd_data;
  logic                 oe_int;
  logic [1:0]           pair;

  dor_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io0(io0_in),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_idle(cs_idle), .io0_s(io0_s)
  );

  dor_cmd_fsm #(.ADDR_BITS(ADDR_BITS), .DUMMY_LONG(DUMMY_LONG)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .rise(sck_rise), .fall(sck_fall),
    .din(io0_s), .ext_addr(ext_addr), .lat_sel(lat_sel), .state(st),
    .load(load), .load_addr(load_addr), .drive(drive)
  );

  dor_serializer #(.ADDR_BITS(ADDR_BITS)) u_ser (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .load(load), .load_addr(load_addr),
    .drive(drive), .rd_data(rd_data), .rd_addr(cur_addr), .dq(dq_out),
    .oe(oe_int), .pair(pair)
  );

  dor_array #(.ADDR_BITS(ADDR_BITS)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(cur_addr), .q(rd_data)
  );

  // raw select gates the enables so a deselect releases the lines at once
  assign dq_oe = {2{oe_int & ~cs_n}};
endmodule

// File: rtl/dual_read_responder_chk.sv
module dual_read_responder_chk
  import dor_pkg::*;
#(
  parameter int ADDR_BITS = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_idle,
  input logic                 drive,
  input rd_state_t            st,
  input logic [1:0]           pair,
  input logic [ADDR_BITS-1:0] cur_addr,
  input logic                 oe_int,
  input logic [1:0]           dq_out,
  input logic [1:0]           dq_oe
);
  AST_OE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_DATA) |-> (dq_oe == 2'b00)); // R11

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !oe_int); // R10

  AST_IDLE_TO_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (st == ST_OPC)); // R9

  AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |=> $stable(dq_out)); // R6

  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    drive |=> (pair == $past(pair) + 2'd1)); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && pair == 2'd0) |=> (cur_addr == $past(cur_addr) + ADDR_BITS'(1))); // R7
endmodule

bind dual_read_responder dual_read_responder_chk #(.ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .drive(drive), .st(st),
  .pair(pair), .cur_addr(cur_addr), .oe_int(oe_int), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/dual_read_responder_test.sv
module dual_read_responder_test;
  localparam int HALF = 8;

  typedef struct packed {
    logic [7:0]  op;
    logic        ext;
    logic        lat;
    logic [31:0] addr;
    logic [7:0]  nb;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h3B, 1'b0, 1'b0, 32'h0000_0010, 8'd3},
    '{8'h3B, 1'b0, 1'b1, 32'h0000_01FF, 8'd3},
    '{8'h3B, 1'b1, 1'b1, 32'h0000_0123, 8'd2},
    '{8'h3C, 1'b0, 1'b0, 32'h1234_0200, 8'd2},
    '{8'h3C, 1'b1, 1'b1, 32'h0000_03FE, 8'd4},
    '{8'h3B, 1'b0, 1'b0, 32'h00FF_FFFF, 8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_addr = 1'b0, lat_sel = 1'b0, cs_n = 1'b1, sck = 1'b0, io0_in = 1'b0;
  logic [1:0] dq_out, dq_oe;
  int checks = 0, fails = 0;
  bit saw_oe;

  always #5 clk = ~clk;

  dual_read_responder uut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .lat_sel(lat_sel),
    .cs_n(cs_n), .sck(sck), .io0_in(io0_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // byte stored at an address, per R12, after the R8 mask
  function automatic logic [7:0] exp_byte(input logic [31:0] a);
    logic [9:0] m;
    m = a[9:0];
    return (m[7:0] ^ 8'hA5) + {6'b0, m[9:8]};
  endfunction

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R1 R4 R12";
      1: return "R5 R7";
      2: return "R2 R4";
      3: return "R3 R8";
      4: return "R3 R5 R8";
      default: return "R1 R8";
    endcase
  endfunction

  // one host clock with a bit on io0_in; records any enable seen before the fall
  task automatic host_bit(input logic b);
    io0_in = b;
    wait_clk(HALF);
    sck = 1'b1;
    wait_clk(HALF);
    if (dq_oe != 2'b00) saw_oe = 1'b1;
    sck = 1'b0;
  endtask

  task automatic send_header(input logic [7:0] op, input logic ext, input logic lat, input logic [31:0] a);
    int alen;
    ext_addr = ext;
    lat_sel  = lat;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(4);
    saw_oe = 1'b0;
    for (int i = 7; i >= 0; i--) host_bit(op[i]);
    alen = (op == 8'h3C || ext) ? 32 : 24;
    for (int i = alen - 1; i >= 0; i--) host_bit(a[i]);
    if (lat) for (int i = 0; i < 8; i++) host_bit(i[0] ^ a[i]);
  endtask

  task automatic read_byte(output logic [7:0] got, input bit first, input string tag);
    for (int p = 0; p < 4; p++) begin
      wait_clk(HALF);
      if (first && p == 0)
        check(dq_oe == 2'b11, {"R11 enable at first data ", tag}, dq_oe, 2'b11);
      got[7-2*p] = dq_out[1];
      got[6-2*p] = dq_out[0];
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic deselect(input string tag);
    cs_n = 1'b1;
    #1;
    check(dq_oe == 2'b00, {"R9 release on deselect ", tag}, dq_oe, 0);
    wait_clk(6);
  endtask

  task automatic run_read(input logic [7:0] op, input logic ext, input logic lat,
                          input logic [31:0] a, input int nb, input string tag);
    logic [7:0] got;
    send_header(op, ext, lat, a);
    check(!saw_oe, {"R11 no enable before data ", tag}, saw_oe, 0);
    for (int b = 0; b < nb; b++) begin
      read_byte(got, b == 0, tag);
      check(got == exp_byte(a + b), {"R6 data ", tag}, got, exp_byte(a + b));
    end
    deselect(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] got;
    wait_clk(3);
    check(dq_oe == 2'b00, "R11 reset enable", dq_oe, 0);
    rst_n = 1'b1;
    wait_clk(3);
    check(dq_oe == 2'b00, "R11 idle after reset", dq_oe, 0);

    for (int i = 0; i < 6; i++)
      run_read(VECS[i].op, VECS[i].ext, VECS[i].lat, VECS[i].addr, int'(VECS[i].nb), vec_tag(i));

    // R9: abort in the middle of a byte, then a fresh read must work
    send_header(8'h3B, 1'b0, 1'b0, 32'h40);
    for (int p = 0; p < 6; p++) begin
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(2);
    check(dq_oe == 2'b11, "R9 enable before abort", dq_oe, 2'b11);
    sck = 1'b1;
    wait_clk(3);
    deselect("abort");
    sck = 1'b0;
    wait_clk(4);
    run_read(8'h3B, 1'b0, 1'b0, 32'h40, 2, "R9 restart");

    // R10: unknown commands keep the lines released, then a valid read recovers
    for (int k = 0; k < 2; k++) begin
      logic [7:0] bad;
      bad = (k == 0) ? 8'h0B : 8'h3D;
      send_header(bad, 1'b0, 1'b0, 32'h00_0010);
      for (int i = 0; i < 24; i++) host_bit(1'b0);
      check(!saw_oe, "R10 unknown command stays quiet", saw_oe, 0);
      deselect("R10");
    end
    run_read(8'h3C, 1'b0, 1'b1, 32'h0000_03FF, 2, "R10 recovery R8");

    // R7: a long read across many bytes
    send_header(8'h3B, 1'b0, 1'b0, 32'h0000_0080);
    for (int b = 0; b < 8; b++) begin
      read_byte(got, b == 0, "R7 long");
      check(got == exp_byte(32'h80 + b), "R7 increment", got, exp_byte(32'h80 + b));
    end
    deselect("R7");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule